// File: doc/BRIEF.md
# Performance-Level Policy Stack Combiner

This block merges the performance requests of several independent policies into one global performance level. Each policy owns a slot in a fixed stack, ordered from slot 0 at the bottom to the highest slot at the top. A slot holds a combine command and a requested level in percent of peak. The stack is folded from the bottom upward to produce one raw level. That raw level is then mapped onto the nearest supported operating point at or above it.

A policy updates its own slot through a valid/ready write port. The other policies never resubmit. A write made outside a system event starts a recomputation. A system event is bracketed by single-cycle open and close pulses. While an event is open, writes land in their slots but the outputs stay frozen. When the event closes, the outputs are recomputed once. This lets every handler of a task switch or similar event adjust its request without causing intermediate output changes.

The outputs are the registered raw level, a registered operating-point index, and a one-cycle strobe raised whenever the index moves.

Top module: `perf_stack_combiner`

## Requirements
- R1: Commands are 2-bit codes. Code 2'b00 passes the running result through unchanged. Code 2'b01 forces the running result to the slot level. Code 2'b10 replaces the running result only when the slot level is strictly greater. Code 2'b11 acts like 2'b00.
- R2: The fold starts from a running result of 0 below slot 0 and visits slots in ascending index. The value after the highest slot is the raw level. For example, slot 0 forcing 25, slot 1 raising to 20 and slot 2 forcing 80 gives 80, and the partial result is 25 after each of the first two slots.
- R3: `wr_ready` is high whenever reset is low. A write accepted outside an open event on rising edge N is applied to its slot on that edge. `perf_raw` and `op_index` take the new fold result on edge N+1. With no pending recompute, `perf_raw` holds its value.
- R4: An event is open from the cycle its open pulse is seen until its close pulse. Writes accepted while it is open update their slots but leave `perf_raw`, `op_index` and `op_change` unchanged.
- R5: A close pulse on edge N causes exactly one recompute, on edge N+1. That recompute includes a write accepted on the same edge N.
- R6: The operating points are 100, 83, 66 and 50 percent, with indices 0, 1, 2 and 3. `op_index` is the index of the lowest point that is at or above the raw level.
- R7: A raw level of 50 or below maps to index 3. A raw level above 100 maps to index 0.
- R8: `op_change` is high for exactly the one cycle after a recompute edge on which `op_index` took a value different from its previous one, and is low otherwise.
- R9: During and right after reset, every slot holds 2'b00, `perf_raw` is 0, `op_index` is 3 and `op_change` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_valid | input | 1 | Slot write request |
| wr_ready | output | 1 | Write port can accept a request |
| wr_slot | input | 2 | Index of the slot to write |
| wr_cmd | input | 2 | Combine command for the slot |
| wr_level | input | 7 | Requested level in percent |
| ev_open | input | 1 | Single-cycle pulse that opens a system event |
| ev_close | input | 1 | Single-cycle pulse that closes a system event |
| perf_raw | output | 7 | Registered global level from the fold |
| op_index | output | 2 | Registered operating-point index, 0 = 100% |
| op_change | output | 1 | One-cycle strobe when `op_index` changes |

## Verification
Several properties are checked on every cycle:
- The index and the strobe move together.
- The raw level holds when no recompute is pending.
- An open event blocks a pending recompute, and a close always schedules one.
- A forcing top slot dictates the fold result.
- Low raw levels land on the slowest point.

Only the bench scenarios can show the full fold under mixed command patterns, such as the worked three-slot example and the strict raise comparison. The same applies to the quantizer boundaries at each operating point, and to the exact recompute latency. Finally, the bench shows that writes made during an event, including one sent together with the close pulse, appear in a single recompute and not before it.

// File: rtl/perf_stack_pkg.sv
package perf_stack_pkg;
  typedef enum logic [1:0] {
    CMD_PASS  = 2'b00,
    CMD_FORCE = 2'b01,
    CMD_RAISE = 2'b10,
    CMD_RSVD  = 2'b11
  } pcmd_e;
endpackage

// File: rtl/slot_bank.sv
module slot_bank #(
  parameter int NUM_SLOTS = 4,
  parameter int LVL_W     = 7,
  localparam int SLOT_W   = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       we,
  input  logic [SLOT_W-1:0]          waddr,
  input  logic [1:0]                 wcmd,
  input  logic [LVL_W-1:0]           wlvl,
  output logic [NUM_SLOTS*2-1:0]     cmd_flat,
  output logic [NUM_SLOTS*LVL_W-1:0] lvl_flat
);
  // Every slot is read at once by the fold, so storage lives in flops.
  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
    logic [1:0]       cmd_q;
    logic [LVL_W-1:0] lvl_q;
    always_ff @(posedge clk) begin
      if (rst) begin
        cmd_q <= perf_stack_pkg::CMD_PASS;
        lvl_q <= '0;
      end else if (we && (int'(waddr) == s)) begin
        cmd_q <= wcmd;
        lvl_q <= wlvl;
      end
    end
    assign cmd_flat[s*2 +: 2]         = cmd_q;
    assign lvl_flat[s*LVL_W +: LVL_W] = lvl_q;
  end
endmodule

// File: rtl/stack_fold.sv
module stack_fold #(
  parameter int NUM_SLOTS = 4,
  parameter int LVL_W     = 7
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [NUM_SLOTS*2-1:0]     cmd_flat,
  input  logic [NUM_SLOTS*LVL_W-1:0] lvl_flat,
  output logic [LVL_W-1:0]           result
);
  import perf_stack_pkg::*;

  logic [LVL_W-1:0] acc [NUM_SLOTS+1];
  assign acc[0] = '0;

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_step
    logic [1:0]       c;
    logic [LVL_W-1:0] l;
    assign c = cmd_flat[s*2 +: 2];
    assign l = lvl_flat[s*LVL_W +: LVL_W];
    assign acc[s+1] = (c == CMD_FORCE) ? l :
                      ((c == CMD_RAISE) && (l > acc[s])) ? l : acc[s];
  end

  assign result = acc[NUM_SLOTS];

  // R2: a forcing top slot decides the final level.
  assert_top_force_wins_R2: assert property (@(posedge clk) disable iff (rst)
    (cmd_flat[(NUM_SLOTS-1)*2 +: 2] == CMD_FORCE) |->
      (result == lvl_flat[(NUM_SLOTS-1)*LVL_W +: LVL_W]));
endmodule

// File: rtl/op_quantizer.sv
module op_quantizer #(
  parameter int LVL_W     = 7,
  parameter int NUM_OPS   = 4,
  parameter int PEAK_PCT  = 100,
  parameter int FLOOR_PCT = 50,
  localparam int IDX_W    = (NUM_OPS > 1) ? $clog2(NUM_OPS) : 1
) (
  input  logic [LVL_W-1:0] raw,
  output logic [IDX_W-1:0] idx
);
  function automatic int op_point(int k);
    return FLOOR_PCT + ((NUM_OPS - 1 - k) * (PEAK_PCT - FLOOR_PCT)) / (NUM_OPS - 1);
  endfunction

  // Points descend with the index, so the count of lower points that still
  // cover the raw level is the index of the lowest covering point.
  always_comb begin
    int cnt;
    cnt = 0;
    for (int k = 1; k < NUM_OPS; k++) begin
      if (int'(raw) <= op_point(k)) cnt++;
    end
    idx = IDX_W'(cnt);
  end
endmodule

// File: rtl/event_gate.sv
module event_gate (
  input  logic clk,
  input  logic rst,
  input  logic ev_open,
  input  logic ev_close,
  input  logic wr_fire,
  output logic pend_q,
  output logic in_event_q
);
  logic hold;
  assign hold = (in_event_q | ev_open) & ~ev_close;

  always_ff @(posedge clk) begin
    if (rst) begin
      in_event_q <= 1'b0;
      pend_q     <= 1'b0;
    end else begin
      in_event_q <= hold;
      pend_q     <= ev_close | (wr_fire & ~hold);
    end
  end

  // R4: while an event stays open, no recompute gets scheduled.
  assert_hold_blocks_R4: assert property (@(posedge clk) disable iff (rst)
    (in_event_q && !ev_close) |=> !pend_q);
  // R5: a close always schedules the batched recompute.
  assert_close_recompute_R5: assert property (@(posedge clk) disable iff (rst)
    ev_close |=> pend_q);
endmodule

// File: rtl/perf_stack_combiner.sv
module perf_stack_combiner #(
  parameter int NUM_SLOTS = 4,
  parameter int LVL_W     = 7,
  parameter int NUM_OPS   = 4,
  parameter int PEAK_PCT  = 100,
  parameter int FLOOR_PCT = 50,
  localparam int SLOT_W   = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1,
  localparam int IDX_W    = (NUM_OPS > 1) ? $clog2(NUM_OPS) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [SLOT_W-1:0] wr_slot,
  input  logic [1:0]        wr_cmd,
  input  logic [LVL_W-1:0]  wr_level,
  input  logic              ev_open,
  input  logic              ev_close,
  output logic [LVL_W-1:0]  perf_raw,
  output logic [IDX_W-1:0]  op_index,
  output logic              op_change
);
  logic                       ready_q;
  logic                       wr_fire;
  logic [NUM_SLOTS*2-1:0]     cmd_flat;
  logic [NUM_SLOTS*LVL_W-1:0] lvl_flat;
  logic [LVL_W-1:0]           fold_lvl;
  logic [IDX_W-1:0]           fold_idx;
  logic                       pend_q;
  logic                       in_event_q;
  logic [LVL_W-1:0]           raw_q;
  logic [IDX_W-1:0]           idx_q;
  logic                       chg_q;

  always_ff @(posedge clk) begin
    if (rst) ready_q <= 1'b0;
    else     ready_q <= 1'b1;
  end
  assign wr_ready = ready_q;
  assign wr_fire  = wr_valid & ready_q;

  slot_bank #(.NUM_SLOTS(NUM_SLOTS), .LVL_W(LVL_W)) u_bank (
    .clk(clk), .rst(rst), .we(wr_fire), .waddr(wr_slot),
    .wcmd(wr_cmd), .wlvl(wr_level), .cmd_flat(cmd_flat), .lvl_flat(lvl_flat)
  );

  stack_fold #(.NUM_SLOTS(NUM_SLOTS), .LVL_W(LVL_W)) u_fold (
    .clk(clk), .rst(rst), .cmd_flat(cmd_flat), .lvl_flat(lvl_flat), .result(fold_lvl)
  );

  op_quantizer #(.LVL_W(LVL_W), .NUM_OPS(NUM_OPS), .PEAK_PCT(PEAK_PCT),
                 .FLOOR_PCT(FLOOR_PCT)) u_quant (
    .raw(fold_lvl), .idx(fold_idx)
  );

  event_gate u_gate (
    .clk(clk), .rst(rst), .ev_open(ev_open), .ev_close(ev_close),
    .wr_fire(wr_fire), .pend_q(pend_q), .in_event_q(in_event_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      raw_q <= '0;
      idx_q <= IDX_W'(NUM_OPS - 1);
      chg_q <= 1'b0;
    end else if (pend_q) begin
      raw_q <= fold_lvl;
      idx_q <= fold_idx;
      chg_q <= (fold_idx != idx_q);
    end else begin
      chg_q <= 1'b0;
    end
  end

  assign perf_raw  = raw_q;
  assign op_index  = idx_q;
  assign op_change = chg_q;

  // R8: the strobe marks a real index move, and every move carries it.
  assert_strobe_means_move_R8: assert property (@(posedge clk) disable iff (rst)
    op_change |-> (op_index != $past(op_index)));
  assert_move_has_strobe_R8: assert property (@(posedge clk) disable iff (rst)
    (op_index != $past(op_index)) |-> op_change);
  // R3: the raw level only moves on a scheduled recompute.
  assert_raw_holds_R3: assert property (@(posedge clk) disable iff (rst)
    !pend_q |=> $stable(perf_raw));
  // R7: low levels sit on the slowest point.
  assert_floor_clamp_R7: assert property (@(posedge clk) disable iff (rst)
    (int'(perf_raw) <= FLOOR_PCT) |-> (int'(op_index) == NUM_OPS - 1));
endmodule

// File: tb/sim_perf_stack_combiner.sv
`timescale 1ns/1ps
module sim_perf_stack_combiner;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_valid = 1'b0;
  logic       wr_ready;
  logic [1:0] wr_slot = '0;
  logic [1:0] wr_cmd = '0;
  logic [6:0] wr_level = '0;
  logic       ev_open = 1'b0;
  logic       ev_close = 1'b0;
  logic [6:0] perf_raw;
  logic [1:0] op_index;
  logic       op_change;

  int total = 0;
  int bad = 0;
  bit done = 0;

  int m_cmd [4];
  int m_lvl [4];
  int exp_raw;
  int exp_idx;

  always #2.5 clk = ~clk;

  perf_stack_combiner u0 (
    .clk(clk), .rst(rst), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_slot(wr_slot), .wr_cmd(wr_cmd), .wr_level(wr_level),
    .ev_open(ev_open), .ev_close(ev_close),
    .perf_raw(perf_raw), .op_index(op_index), .op_change(op_change)
  );

  function automatic int fold_model();
    int acc;
    acc = 0;
    for (int s = 0; s < 4; s++) begin
      if (m_cmd[s] == 1) acc = m_lvl[s];
      else if (m_cmd[s] == 2 && m_lvl[s] > acc) acc = m_lvl[s];
    end
    return acc;
  endfunction

  function automatic int quant_model(int raw);
    if (raw > 83) return 0;
    if (raw > 66) return 1;
    if (raw > 50) return 2;
    return 3;
  endfunction

  task automatic check(string req, int act, int expv);
    total++;
    if (act != expv) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  // Presents one write; returns at the negedge after the accepting edge.
  task automatic put(int slot, int cmd, int lvl, bit close_too = 0);
    wr_valid = 1'b1;
    wr_slot  = 2'(slot);
    wr_cmd   = 2'(cmd);
    wr_level = 7'(lvl);
    ev_close = close_too;
    @(posedge clk);
    @(negedge clk);
    wr_valid = 1'b0;
    ev_close = 1'b0;
    m_cmd[slot] = cmd;
    m_lvl[slot] = lvl;
  endtask

  // Waits for the recompute edge and checks all outputs.
  task automatic settle_check(string req);
    int nr;
    int ni;
    @(posedge clk);
    @(negedge clk);
    nr = fold_model();
    ni = quant_model(nr);
    check({req, " raw"}, int'(perf_raw), nr);
    check({req, " idx"}, int'(op_index), ni);
    check({req, " strobe"}, int'(op_change), (ni != exp_idx) ? 1 : 0);
    exp_raw = nr;
    exp_idx = ni;
  endtask

  task automatic wr_check(int slot, int cmd, int lvl, string req);
    put(slot, cmd, lvl);
    settle_check(req);
  endtask

  task automatic clear_all();
    for (int s = 0; s < 4; s++) wr_check(s, 0, 0, "R1 clear");
  endtask

  initial begin
    #(200000 * 5.0);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int seed;
    seed = 32'h5eed_1234;
    void'($urandom(seed));
    for (int s = 0; s < 4; s++) begin
      m_cmd[s] = 0;
      m_lvl[s] = 0;
    end
    repeat (5) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R9 reset state
    check("R9 raw", int'(perf_raw), 0);
    check("R9 idx", int'(op_index), 3);
    check("R9 strobe", int'(op_change), 0);
    check("R3 ready", int'(wr_ready), 1);
    exp_raw = 0;
    exp_idx = 3;

    // R2 worked example
    wr_check(0, 1, 25, "R2 slot0");
    check("R2 after slot0", int'(perf_raw), 25);
    wr_check(1, 2, 20, "R2 slot1");
    check("R2 after slot1", int'(perf_raw), 25);
    wr_check(2, 1, 80, "R2 slot2");
    check("R2 final", int'(perf_raw), 80);
    @(negedge clk);
    check("R8 strobe one cycle", int'(op_change), 0);

    // R1: code 3 acts as pass-through; raise must be strictly greater
    wr_check(2, 3, 99, "R1 rsvd");
    check("R1 rsvd pass", int'(perf_raw), 25);
    wr_check(3, 2, 90, "R1 raise");
    check("R1 raise above", int'(perf_raw), 90);
    wr_check(3, 0, 90, "R1 ignore");
    check("R1 ignore", int'(perf_raw), 25);

    // R3 latency: nothing visible on the accepting edge itself
    put(0, 1, 70);
    check("R3 not yet raw", int'(perf_raw), 25);
    settle_check("R3 latency");

    // R6/R7 quantizer boundaries through slot 0 alone
    clear_all();
    begin
      int pts [10] = '{83, 84, 66, 67, 50, 51, 0, 127, 100, 101};
      int exps [10] = '{1, 0, 2, 1, 3, 2, 3, 0, 0, 0};
      for (int i = 0; i < 10; i++) begin
        wr_check(0, 1, pts[i], "R6 boundary");
        check(i >= 6 ? "R7 clamp" : "R6 point", int'(op_index), exps[i]);
      end
    end

    // R4/R5 event batching
    clear_all();
    wr_check(0, 1, 60, "R4 pre");
    ev_open = 1'b1;
    put(1, 1, 95);
    ev_open = 1'b0;
    check("R4 raw held", int'(perf_raw), exp_raw);
    @(negedge clk);
    check("R4 raw held2", int'(perf_raw), exp_raw);
    put(2, 2, 40);
    @(negedge clk);
    check("R4 raw held3", int'(perf_raw), exp_raw);
    check("R4 strobe low", int'(op_change), 0);
    put(3, 2, 99, 1'b1);
    check("R5 not before", int'(perf_raw), exp_raw);
    settle_check("R5 close");
    check("R5 includes close write", int'(perf_raw), 99);
    @(negedge clk);
    check("R5 single strobe", int'(op_change), 0);
    check("R5 stays", int'(perf_raw), 99);

    // Random phase, with occasional events
    for (int it = 0; it < 400; it++) begin
      int sl;
      int cm;
      int lv;
      sl = $urandom_range(3, 0);
      cm = $urandom_range(3, 0);
      lv = ($urandom_range(9, 0) == 0) ? $urandom_range(127, 101) : $urandom_range(100, 0);
      if ($urandom_range(19, 0) == 0) begin
        ev_open = 1'b1;
        put(sl, cm, lv);
        ev_open = 1'b0;
        check("R4 rnd hold", int'(perf_raw), exp_raw);
        put($urandom_range(3, 0), $urandom_range(3, 0), $urandom_range(100, 0), 1'b1);
        settle_check("R5 rnd close");
      end else begin
        wr_check(sl, cm, lv, "R1 R2 R6 rnd");
      end
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule